// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is a sequential integer multiply and divide engine that keeps its results in two dedicated result registers, HI and LO, rather than in a general destination. A command port accepts a 6-bit function code with two operands. Four codes start a long operation: signed or unsigned multiply, and signed or unsigned divide. Four codes move data: a copy from HI or LO to the read port, or a copy of the first operand into HI or LO.

Long operations work one bit per cycle. A shift-add loop handles multiply and a restoring loop handles divide. Both loops run on operand magnitudes. Signs are removed before the loop and put back after it. While an operation runs, `busy` is high and `cmd_ready` is low. Any command offered in that window, including a move, is held off until the result has been committed. The unit raises no exceptions. A zero divisor still completes in the normal number of cycles, with a fixed result.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After reset, `busy` is 0, `cmd_ready` is 1, and both HI and LO read back as zero.
- R2: Function 0x19 (unsigned multiply) leaves the low half of the 2*WIDTH-bit unsigned product in LO and the high half in HI.
- R3: Function 0x18 (signed multiply) leaves the two's-complement 2*WIDTH-bit product of the signed operands, low half in LO and high half in HI.
- R4: Function 0x1B (unsigned divide) leaves the quotient `a/b` in LO and the remainder `a%b` in HI.
- R5: Function 0x1A (signed divide) truncates the quotient toward zero, and the remainder takes the dividend's sign. The most negative value divided by -1 gives the most negative value in LO and zero in HI.
- R6: When the divisor is zero, a divide of either kind gives all-ones in LO and the unmodified dividend in HI, in the same cycle count as any other divide.
- R7: Once a start command is accepted at a clock edge, `busy` is high for exactly WIDTH+1 cycles and then returns low.
- R8: While `busy` is high, `cmd_ready` is 0, `rd_valid` is 0 and HI/LO do not change before the commit. A command held valid in that window takes effect only after completion.
- R9: When accepted, function 0x10 (read HI) or 0x12 (read LO) raises `rd_valid` in the same cycle, with `rd_data` equal to that register.
- R10: Function 0x11 writes `cmd_src_a` into HI and function 0x13 writes it into LO, at the accepting edge. The other register is left unchanged.
- R11: Any other function code is accepted and has no effect: HI, LO and `busy` stay unchanged, and `rd_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_ready | output | 1 | Unit can accept a command (idle) |
| cmd_func | input | 6 | Function code |
| cmd_src_a | input | WIDTH | First operand: multiplicand or dividend, or move-to data |
| cmd_src_b | input | WIDTH | Second operand: multiplier or divisor |
| busy | output | 1 | Long operation in progress |
| rd_valid | output | 1 | Read data valid for an accepted read of HI or LO |
| rd_data | output | WIDTH | HI or LO contents for the accepted read |

## Verification
The bench sweeps a set of boundary and patterned 8-bit operands through all four long operations. The set includes zero, one, the extremes of each sign and alternating-bit patterns. It targets these failures:
- a sign fix that rounds toward minus infinity, or gives the remainder the divisor's sign;
- negation of the most negative value, which a careless magnitude step would corrupt;
- a divide-by-zero path that negates the all-ones quotient or drops the dividend;
- a subtraction in the restoring step that is too narrow and loses the borrow when the shifted remainder reaches the top bit.

The remaining checks cover three things:
- Every operation's busy span is counted, so an off-by-one loop bound shows up even when the value comes out right.
- A move-to held valid across a busy window shows whether a design lets it slip in early or lets the commit overwrite it.
- Unknown function codes are checked for side effects on HI, LO and `busy`.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  typedef enum logic [5:0] {
    FN_MFHI = 6'h10,
    FN_MTHI = 6'h11,
    FN_MFLO = 6'h12,
    FN_MTLO = 6'h13,
    FN_MULS = 6'h18,
    FN_MULU = 6'h19,
    FN_DIVS = 6'h1A,
    FN_DIVU = 6'h1B
  } fn_code_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

endpackage

// File: rtl/hilo_operand_prep.sv
module hilo_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic             signed_op,
  output logic [WIDTH-1:0] mag_a,
  output logic [WIDTH-1:0] mag_b,
  output logic             neg_main,
  output logic             neg_rem
);

  function automatic logic [WIDTH-1:0] magnitude(logic [WIDTH-1:0] v, logic s);
    return (s && v[WIDTH-1]) ? -v : v;
  endfunction

  always_comb begin
    mag_a    = magnitude(src_a, signed_op);
    mag_b    = magnitude(src_b, signed_op);
    // a zero divisor keeps the all-ones quotient unnegated
    neg_main = signed_op && (src_a[WIDTH-1] ^ src_b[WIDTH-1]) && (|src_b);
    neg_rem  = signed_op && src_a[WIDTH-1];
  end

endmodule

// File: rtl/hilo_iter_core.sv
module hilo_iter_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             is_div,
  input  logic [WIDTH-1:0] mag_a,
  input  logic [WIDTH-1:0] mag_b,
  output logic [WIDTH-1:0] acc_hi,
  output logic [WIDTH-1:0] acc_lo
);

  localparam int PAIR_W = 2 * WIDTH;

  logic [WIDTH-1:0]  hi_q, lo_q, opb_q;
  logic [PAIR_W-1:0] nxt_pair;

  // one shift-add round: add the operand when the low bit is set, then shift right
  function automatic logic [PAIR_W-1:0] mul_round(logic [WIDTH-1:0] h,
                                                  logic [WIDTH-1:0] l,
                                                  logic [WIDTH-1:0] m);
    logic [WIDTH:0] s;
    s = {1'b0, h} + (l[0] ? {1'b0, m} : {(WIDTH+1){1'b0}});
    return {s, l[WIDTH-1:1]};
  endfunction

  // one restoring round: shift in a dividend bit, keep the difference if it is not negative
  function automatic logic [PAIR_W-1:0] div_round(logic [WIDTH-1:0] h,
                                                  logic [WIDTH-1:0] l,
                                                  logic [WIDTH-1:0] d);
    logic [WIDTH:0]   sh;
    logic [WIDTH+1:0] df;
    sh = {h, l[WIDTH-1]};
    df = {1'b0, sh} - {2'b00, d};
    if (df[WIDTH+1]) return {sh[WIDTH-1:0], l[WIDTH-2:0], 1'b0};
    else             return {df[WIDTH-1:0], l[WIDTH-2:0], 1'b1};
  endfunction

  always_comb begin
    nxt_pair = is_div ? div_round(hi_q, lo_q, opb_q) : mul_round(hi_q, lo_q, opb_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      opb_q <= '0;
    end else if (load) begin
      hi_q  <= '0;
      lo_q  <= mag_a;
      opb_q <= mag_b;
    end else if (step) begin
      hi_q <= nxt_pair[PAIR_W-1:WIDTH];
      lo_q <= nxt_pair[WIDTH-1:0];
    end
  end

  assign acc_hi = hi_q;
  assign acc_lo = lo_q;

endmodule

// File: rtl/hilo_result_fix.sv
module hilo_result_fix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] acc_hi,
  input  logic [WIDTH-1:0] acc_lo,
  input  logic             is_div,
  input  logic             neg_main,
  input  logic             neg_rem,
  output logic [WIDTH-1:0] res_hi,
  output logic [WIDTH-1:0] res_lo
);

  localparam int PAIR_W = 2 * WIDTH;

  function automatic logic [PAIR_W-1:0] fix_product(logic [PAIR_W-1:0] p, logic n);
    return n ? -p : p;
  endfunction

  function automatic logic [WIDTH-1:0] fix_word(logic [WIDTH-1:0] v, logic n);
    return n ? -v : v;
  endfunction

  logic [PAIR_W-1:0] prod;

  always_comb begin
    prod = fix_product({acc_hi, acc_lo}, neg_main);
    if (is_div) begin
      res_lo = fix_word(acc_lo, neg_main);
      res_hi = fix_word(acc_hi, neg_rem);
    end else begin
      res_lo = prod[WIDTH-1:0];
      res_hi = prod[PAIR_W-1:WIDTH];
    end
  end

endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit
  import hilo_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [5:0]       cmd_func,
  input  logic [WIDTH-1:0] cmd_src_a,
  input  logic [WIDTH-1:0] cmd_src_b,
  output logic             busy,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] step_cnt_q;
  logic [WIDTH-1:0] hi_q, lo_q;
  logic             r_is_div, r_neg_main, r_neg_rem;

  // named internal events
  logic cmd_fire, start_fire, step_fire, commit_fire;
  logic mt_hi_fire, mt_lo_fire, mf_fire;
  logic is_start, signed_op, start_div;

  logic [WIDTH-1:0] mag_a, mag_b, acc_hi, acc_lo, res_hi, res_lo;
  logic             neg_main, neg_rem;

  assign cmd_ready   = (phase_q == PH_IDLE);
  assign busy        = (phase_q != PH_IDLE);
  assign cmd_fire    = cmd_valid && cmd_ready;
  assign is_start    = (cmd_func == FN_MULS) || (cmd_func == FN_MULU) ||
                       (cmd_func == FN_DIVS) || (cmd_func == FN_DIVU);
  assign signed_op   = (cmd_func == FN_MULS) || (cmd_func == FN_DIVS);
  assign start_div   = (cmd_func == FN_DIVS) || (cmd_func == FN_DIVU);
  assign start_fire  = cmd_fire && is_start;
  assign mt_hi_fire  = cmd_fire && (cmd_func == FN_MTHI);
  assign mt_lo_fire  = cmd_fire && (cmd_func == FN_MTLO);
  assign mf_fire     = cmd_fire && ((cmd_func == FN_MFHI) || (cmd_func == FN_MFLO));
  assign step_fire   = (phase_q == PH_RUN);
  assign commit_fire = (phase_q == PH_DONE);

  hilo_operand_prep #(.WIDTH(WIDTH)) prep_i (
    .src_a     (cmd_src_a),
    .src_b     (cmd_src_b),
    .signed_op (signed_op),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .neg_main  (neg_main),
    .neg_rem   (neg_rem)
  );

  hilo_iter_core #(.WIDTH(WIDTH)) core_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start_fire),
    .step   (step_fire),
    .is_div (r_is_div),
    .mag_a  (mag_a),
    .mag_b  (mag_b),
    .acc_hi (acc_hi),
    .acc_lo (acc_lo)
  );

  hilo_result_fix #(.WIDTH(WIDTH)) fix_i (
    .acc_hi   (acc_hi),
    .acc_lo   (acc_lo),
    .is_div   (r_is_div),
    .neg_main (r_neg_main),
    .neg_rem  (r_neg_rem),
    .res_hi   (res_hi),
    .res_lo   (res_lo)
  );

  // sequencing: idle -> WIDTH step cycles -> one commit cycle -> idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      step_cnt_q <= '0;
      r_is_div   <= 1'b0;
      r_neg_main <= 1'b0;
      r_neg_rem  <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_fire) begin
          phase_q    <= PH_RUN;
          step_cnt_q <= '0;
          r_is_div   <= start_div;
          r_neg_main <= neg_main;
          r_neg_rem  <= neg_rem;
        end
        PH_RUN: begin
          if (step_cnt_q == LAST_STEP) phase_q <= PH_DONE;
          else step_cnt_q <= step_cnt_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (commit_fire) begin
      hi_q <= res_hi;
      lo_q <= res_lo;
    end else begin
      if (mt_hi_fire) hi_q <= cmd_src_a;
      if (mt_lo_fire) lo_q <= cmd_src_a;
    end
  end

  assign rd_valid = mf_fire;
  assign rd_data  = !mf_fire ? '0 : ((cmd_func == FN_MFHI) ? hi_q : lo_q);

endmodule

// File: rtl/hilo_muldiv_checker.sv
module hilo_muldiv_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [5:0]       cmd_func,
  input logic [WIDTH-1:0] cmd_src_a,
  input logic             busy,
  input logic             rd_valid,
  input logic             start_fire,
  input logic             commit_fire,
  input logic [WIDTH-1:0] hi_q,
  input logic [WIDTH-1:0] lo_q
);

  localparam int RC_W = $clog2(WIDTH + 2) + 1;

  logic [RC_W-1:0] run_cnt;
  logic            known_fn, acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else        run_cnt <= busy ? run_cnt + 1'b1 : '0;
  end

  assign acc      = cmd_valid && cmd_ready;
  assign known_fn = (cmd_func >= 6'h10 && cmd_func <= 6'h13) ||
                    (cmd_func >= 6'h18 && cmd_func <= 6'h1B);

  AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!cmd_ready && !rd_valid)); // R8
  AST_HILO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit_fire) |=> ($stable(hi_q) && $stable(lo_q))); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> busy); // R7
  AST_COMMIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> !busy); // R7
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> (run_cnt == RC_W'(WIDTH))); // R7
  AST_MOVE_TO_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_func == 6'h11) |=> (hi_q == $past(cmd_src_a) && $stable(lo_q))); // R10
  AST_MOVE_TO_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_func == 6'h13) |=> (lo_q == $past(cmd_src_a) && $stable(hi_q))); // R10
  AST_UNKNOWN_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !known_fn) |=> ($stable(hi_q) && $stable(lo_q) && !busy)); // R11
  AST_READ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (acc && (cmd_func == 6'h10 || cmd_func == 6'h12))); // R9

endmodule

bind hilo_muldiv_unit hilo_muldiv_checker #(.WIDTH(WIDTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_func    (cmd_func),
  .cmd_src_a   (cmd_src_a),
  .busy        (busy),
  .rd_valid    (rd_valid),
  .start_fire  (start_fire),
  .commit_fire (commit_fire),
  .hi_q        (hi_q),
  .lo_q        (lo_q)
);

// File: tb/hilo_muldiv_unit_tb_top.sv
module hilo_muldiv_unit_tb_top;

  localparam int W      = 8;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [5:0]   cmd_func = '0;
  logic [W-1:0] cmd_src_a = '0;
  logic [W-1:0] cmd_src_b = '0;
  logic         busy;
  logic         rd_valid;
  logic [W-1:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  hilo_muldiv_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_func(cmd_func), .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // reference: {hi, lo} from plain integer arithmetic
  function automatic logic [2*W-1:0] model(logic [5:0] f, logic [W-1:0] a, logic [W-1:0] b);
    longint sa, sb, ua, ub, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = longint'(a);
    ub = longint'(b);
    case (f)
      6'h19: r = ua * ub;
      6'h18: r = sa * sb;
      6'h1B: if (b == 0) return {a, {W{1'b1}}};
             else begin r = ((ua % ub) << W) | (ua / ub); end
      default: if (b == 0) return {a, {W{1'b1}}};
             else begin r = (((sa % sb) & ((1 << W) - 1)) << W) | ((sa / sb) & ((1 << W) - 1)); end
    endcase
    return r[2*W-1:0];
  endfunction

  task automatic issue(logic [5:0] f, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_func = f; cmd_src_a = a; cmd_src_b = b;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic read_reg(logic [5:0] f, output logic [W-1:0] d, output logic v);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_func = f;
    #1;
    v = rd_valid; d = rd_data;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic run_op(string tag, logic [5:0] f, logic [W-1:0] a, logic [W-1:0] b);
    int span;
    logic [W-1:0] hv, lv;
    logic vh, vl;
    logic [2*W-1:0] exp;
    issue(f, a, b);
    span = 0;
    @(negedge clk);
    while (busy) begin span++; @(negedge clk); end
    chk("R7 busy span", span, W + 1);
    exp = model(f, a, b);
    read_reg(6'h10, hv, vh);
    read_reg(6'h12, lv, vl);
    chk({tag, " HI"}, {vh, hv}, {1'b1, exp[2*W-1:W]});
    chk({tag, " LO"}, {vl, lv}, {1'b1, exp[W-1:0]});
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] d;
    logic v;
    logic [W-1:0] vals [16] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h07, 8'h0F, 8'h10,
                                8'h3C, 8'h55, 8'h7E, 8'h7F, 8'h80, 8'h81, 8'hAA, 8'hFF};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 ready", cmd_ready, 1);
    read_reg(6'h10, d, v); chk("R1 HI", {v, d}, {1'b1, 8'h00});
    read_reg(6'h12, d, v); chk("R1 LO", {v, d}, {1'b1, 8'h00});

    // R10 move-to, each leaves the other register alone
    issue(6'h11, 8'h5A, 8'h00);
    read_reg(6'h10, d, v); chk("R10 HI written", d, 8'h5A);
    read_reg(6'h12, d, v); chk("R10 LO untouched", d, 8'h00);
    issue(6'h13, 8'hC3, 8'h00);
    read_reg(6'h12, d, v); chk("R10 LO written", d, 8'hC3);
    read_reg(6'h10, d, v); chk("R9 HI read", {v, d}, {1'b1, 8'h5A});

    // R11 unknown codes are inert
    issue(6'h20, 8'h11, 8'h22);
    #1 chk("R11 busy after 0x20", busy, 0);
    issue(6'h3F, 8'h33, 8'h44);
    @(negedge clk); #1 chk("R11 rd_valid idle", rd_valid, 0);
    read_reg(6'h10, d, v); chk("R11 HI kept", d, 8'h5A);
    read_reg(6'h12, d, v); chk("R11 LO kept", d, 8'hC3);

    // R5 corner: most negative by -1
    run_op("R5 min/-1", 6'h1A, 8'h80, 8'hFF);
    // R6 divide by zero, both kinds
    run_op("R6 divu/0", 6'h1B, 8'hB7, 8'h00);
    run_op("R6 divs/0", 6'h1A, 8'hB7, 8'h00);
    run_op("R6 divs pos/0", 6'h1A, 8'h25, 8'h00);

    // R8 stall: read and move-to offered during a divide
    issue(6'h1B, 8'd200, 8'd7);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_func = 6'h10;
    #1;
    chk("R8 ready low while busy", cmd_ready, 0);
    chk("R8 no read while busy", rd_valid, 0);
    cmd_func = 6'h11; cmd_src_a = 8'h33;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    read_reg(6'h10, d, v); chk("R8 held move-to lands after commit", d, 8'h33);
    read_reg(6'h12, d, v); chk("R8 quotient committed", d, 8'd28);

    // sweep of all four long operations
    foreach (vals[i]) begin
      foreach (vals[j]) begin
        run_op("R2 mulu", 6'h19, vals[i], vals[j]);
        run_op("R3 muls", 6'h18, vals[i], vals[j]);
        run_op(vals[j] == 0 ? "R6 divu" : "R4 divu", 6'h1B, vals[i], vals[j]);
        run_op(vals[j] == 0 ? "R6 divs" : "R5 divs", 6'h1A, vals[i], vals[j]);
      end
    end

    summary();
    $finish;
  end

endmodule